// File: doc/BRIEF.md
# Receive FIFO Pause-Frame Flow Controller

This block sits beside the receive FIFO of an Ethernet MAC. It tracks how many bytes the FIFO holds and decides when the transmit path should send a pause frame. When the FIFO nears full, the block raises a request that carries the largest pause time. When the FIFO has drained far enough, it raises a request with a zero pause time, which tells the link partner to resume. Two separate threshold levels give hysteresis, so the block cannot chatter between the two states. While the partner is paused, the block repeats the pause request at a fixed interval so that the partner stays paused.

Each threshold is a 3-bit code read from fixed bit positions of a 32-bit DMA control word. A code selects the level "FIFO capacity minus N KB". The block checks both codes against the FIFO capacity, which is fixed at build time. A bad pair of codes raises an error flag and blocks all pause generation. A FIFO smaller than 4 KB disables flow control with no error. A transmit arbiter collects requests through a request/acknowledge handshake.

On the receive side, the block flags incoming pause frames and reports their pause quanta. It always accepts frames sent to the reserved pause multicast address. It also accepts frames sent to the station's own unicast address when that option is enabled.

Top module: `rx_pause_flow_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after, `pause_req`, `xoff_active`, `cfg_err` and `rx_pause_hit` are 0.
- R2: The activation code is {`dma_ctrl[23]`,`dma_ctrl[10:9]`}. The deactivation code is {`dma_ctrl[22]`,`dma_ctrl[12:11]`}. A code c selects the level FIFO_BYTES − (c+1)·1024 bytes. A change to `dma_ctrl` takes effect two clock edges later.
- R3: In the released (XON) state, a level at or above the activation level moves the block to XOFF at the next edge. It also raises `pause_req` with `pause_time` = 0xFFFF at that edge. A level one byte below the activation level does nothing.
- R4: In XOFF, any level above the deactivation level keeps the block in XOFF.
- R5: In XOFF, a level at or below the deactivation level returns the block to XON at the next edge. If `zero_quanta_dis` = 0, it also raises `pause_req` with `pause_time` = 0. If `zero_quanta_dis` = 1, it drops any pending request.
- R6: `pause_req` and `pause_time` hold steady until `pause_ack` is sampled high. `pause_req` falls at that edge, unless a new request is raised at the same edge.
- R7: In XOFF, the XOFF request is raised again every REFRESH_QUANTA·QUANTUM_CLKS clock edges, counted from entry into XOFF.
- R8: Code 7 is never legal. Codes 0–2 need FIFO_BYTES ≥ 4096, code 3 needs FIFO_BYTES > 4096, and codes 4–6 need FIFO_BYTES > 8192. The deactivation code must be greater than the activation code. Any violation sets `cfg_err`, forces XON and keeps `pause_req` low.
- R9: With FIFO_BYTES < 4096, `pause_req` and `cfg_err` stay 0 for any level and any codes.
- R10: With `tx_fc_en` = 0, the block is held in XON with no request.
- R11: A pulse on `rx_frame_valid` counts as a pause frame when type = 0x8808, opcode = 0x0001 and the destination is 01:80:C2:00:00:01. A destination equal to `station_addr` also counts when `uni_pause_en` = 1. A counted frame gives a one-cycle `rx_pause_hit` with its quanta on the next edge. Nothing is flagged when `rx_fc_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_ctrl | input | 32 | Control word holding the two threshold codes |
| tx_fc_en | input | 1 | Enables pause generation |
| rx_fc_en | input | 1 | Enables pause-frame detection on receive |
| uni_pause_en | input | 1 | Also accept pause frames sent to the station's unicast address |
| zero_quanta_dis | input | 1 | Suppresses the zero-quanta release frame |
| rx_fifo_level | input | clog2(FIFO_BYTES+1) | Receive FIFO occupancy in bytes |
| pause_req | output | 1 | Pause frame request to the transmit arbiter |
| pause_time | output | 16 | Pause quanta for the requested frame |
| pause_ack | input | 1 | Arbiter has taken the request |
| xoff_active | output | 1 | Block is in the XOFF state |
| cfg_err | output | 1 | Threshold codes are illegal for this FIFO size |
| rx_frame_valid | input | 1 | One-cycle strobe: parsed header fields are valid |
| rx_dest_addr | input | 48 | Destination MAC address of the received frame |
| rx_ethertype | input | 16 | Type field |
| rx_opcode | input | 16 | MAC control opcode |
| rx_quanta | input | 16 | Pause quanta field |
| station_addr | input | 48 | Station's own unicast address |
| rx_pause_hit | output | 1 | One-cycle flag: an accepted pause frame was seen |
| rx_pause_quanta | output | 16 | Quanta of the last accepted pause frame |

## Verification
A level or acknowledge driven before an edge changes `pause_req`, `pause_time` and `xoff_active` at that edge. The bench therefore drives inputs on the falling edge and checks the outputs on the next falling edge. A change to `dma_ctrl` or to the build-time FIFO checks passes through one register stage before the state machine sees it, so the bench waits two edges before it checks `cfg_err` or the effect of new thresholds. The refresh check counts the edges from entry into XOFF and samples just before and just after the expected refresh edge. Received pause frames are checked one edge after their strobe, and again one edge later to confirm the flag is a single-cycle pulse.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
  localparam int          KB_BYTES     = 1024;
  localparam logic [47:0] PAUSE_MCAST  = 48'h0180C2000001;
  localparam logic [15:0] PAUSE_ETYPE  = 16'h8808;
  localparam logic [15:0] PAUSE_OPCODE = 16'h0001;
  localparam logic [15:0] XOFF_TIME    = 16'hFFFF;
  localparam logic [15:0] XON_TIME     = 16'h0000;

  typedef enum logic {FC_XON = 1'b0, FC_XOFF = 1'b1} fc_state_e;

  function automatic logic [2:0] act_code(input logic [31:0] w);
    return {w[23], w[10:9]};
  endfunction

  function automatic logic [2:0] deact_code(input logic [31:0] w);
    return {w[22], w[12:11]};
  endfunction

  // legality of a threshold code for a given FIFO capacity
  function automatic logic code_legal(input logic [2:0] c, input int fifo_bytes);
    if (c <= 3'd2)      return fifo_bytes >= 4 * KB_BYTES;
    else if (c == 3'd3) return fifo_bytes > 4 * KB_BYTES;
    else if (c <= 3'd6) return fifo_bytes > 8 * KB_BYTES;
    else                return 1'b0;
  endfunction
endpackage

// File: rtl/rxfc_thresh_decode.sv
module rxfc_thresh_decode
  import rxfc_pkg::*;
#(
  parameter int FIFO_BYTES = 16384,
  parameter int LVL_W      = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      ctrl_word,
  output logic [LVL_W-1:0] act_lvl,
  output logic [LVL_W-1:0] deact_lvl,
  output logic             cfg_err,
  output logic             fc_ok
);
  localparam bit FIFO_OK = (FIFO_BYTES >= 4 * KB_BYTES);

  function automatic logic [LVL_W-1:0] level_of(input logic [2:0] c);
    int t;
    t = FIFO_BYTES - (int'(c) + 1) * KB_BYTES;
    if (t < 0) t = 0;
    return LVL_W'(t);
  endfunction

  logic [2:0] ac, dc;
  logic       bad;

  always_comb begin
    ac  = act_code(ctrl_word);
    dc  = deact_code(ctrl_word);
    bad = !(code_legal(ac, FIFO_BYTES) && code_legal(dc, FIFO_BYTES) && (dc > ac));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_lvl   <= '0;
      deact_lvl <= '0;
      cfg_err   <= 1'b0;
      fc_ok     <= 1'b0;
    end else begin
      act_lvl   <= level_of(ac);
      deact_lvl <= level_of(dc);
      cfg_err   <= FIFO_OK && bad;
      fc_ok     <= FIFO_OK && !bad;
    end
  end

  generate
    if (FIFO_OK) begin : g_sized
      assert_rsvd_code_R8: assert property (@(posedge clk) disable iff (rst)
        ((ac == 3'd7) || (dc == 3'd7)) |=> (cfg_err && !fc_ok));
    end else begin : g_small
      assert_small_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!cfg_err && !fc_ok));
    end
  endgenerate
endmodule

// File: rtl/rxfc_pause_fsm.sv
module rxfc_pause_fsm
  import rxfc_pkg::*;
#(
  parameter int LVL_W        = 15,
  parameter int REFRESH_CLKS = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] act_lvl,
  input  logic [LVL_W-1:0] deact_lvl,
  input  logic             zq_dis,
  input  logic             ack,
  output logic             req,
  output logic [15:0]      ptime,
  output logic             xoff
);
  localparam int CNT_W = (REFRESH_CLKS > 1) ? $clog2(REFRESH_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REFRESH_CLKS - 1);

  fc_state_e        st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= FC_XON;
      req   <= 1'b0;
      ptime <= XON_TIME;
      cnt   <= '0;
    end else if (!run) begin
      st  <= FC_XON;
      req <= 1'b0;
      cnt <= '0;
    end else if (st == FC_XON) begin
      if (level >= act_lvl) begin
        st    <= FC_XOFF;
        req   <= 1'b1;
        ptime <= XOFF_TIME;
        cnt   <= '0;
      end else if (ack) begin
        req <= 1'b0;
      end
    end else begin
      if (level <= deact_lvl) begin
        st    <= FC_XON;
        cnt   <= '0;
        req   <= !zq_dis;
        ptime <= XON_TIME;
      end else if (cnt == CNT_LAST) begin
        req   <= 1'b1;
        ptime <= XOFF_TIME;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
        if (ack) req <= 1'b0;
      end
    end
  end

  assign xoff = (st == FC_XOFF);

  assert_xoff_time_R3: assert property (@(posedge clk) disable iff (rst)
    (req && st == FC_XOFF) |-> (ptime == XOFF_TIME));
  assert_xon_time_R5: assert property (@(posedge clk) disable iff (rst)
    (req && st == FC_XON) |-> (ptime == XON_TIME));
  assert_no_chatter_R4: assert property (@(posedge clk) disable iff (rst)
    (run && st == FC_XOFF && level > deact_lvl) |=> (st == FC_XOFF));
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (req && !ack && run && st == FC_XON && level < act_lvl) |=> (req && $stable(ptime)));
  assert_halt_R10: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!req && st == FC_XON));
endmodule

// File: rtl/rxfc_rx_detect.sv
module rxfc_rx_detect
  import rxfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_en,
  input  logic        uni_en,
  input  logic [47:0] station,
  input  logic        valid,
  input  logic [47:0] da,
  input  logic [15:0] etype,
  input  logic [15:0] opcode,
  input  logic [15:0] quanta,
  output logic        hit,
  output logic [15:0] hit_quanta
);
  logic addr_ok, match;

  always_comb begin
    addr_ok = (da == PAUSE_MCAST) || (uni_en && da == station);
    match   = rx_en && valid && addr_ok && etype == PAUSE_ETYPE && opcode == PAUSE_OPCODE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit        <= 1'b0;
      hit_quanta <= '0;
    end else begin
      hit <= match;
      if (match) hit_quanta <= quanta;
    end
  end

  assert_rx_gate_R11: assert property (@(posedge clk) disable iff (rst)
    (!rx_en || !valid) |=> !hit);
endmodule

// File: rtl/rx_pause_flow_ctrl.sv
module rx_pause_flow_ctrl
  import rxfc_pkg::*;
#(
  parameter int FIFO_BYTES     = 16384,
  parameter int QUANTUM_CLKS   = 64,
  parameter int REFRESH_QUANTA = 32768
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [31:0]                        dma_ctrl,
  input  logic                               tx_fc_en,
  input  logic                               rx_fc_en,
  input  logic                               uni_pause_en,
  input  logic                               zero_quanta_dis,
  input  logic [$clog2(FIFO_BYTES+1)-1:0]    rx_fifo_level,
  output logic                               pause_req,
  output logic [15:0]                        pause_time,
  input  logic                               pause_ack,
  output logic                               xoff_active,
  output logic                               cfg_err,
  input  logic                               rx_frame_valid,
  input  logic [47:0]                        rx_dest_addr,
  input  logic [15:0]                        rx_ethertype,
  input  logic [15:0]                        rx_opcode,
  input  logic [15:0]                        rx_quanta,
  input  logic [47:0]                        station_addr,
  output logic                               rx_pause_hit,
  output logic [15:0]                        rx_pause_quanta
);
  localparam int LVL_W        = $clog2(FIFO_BYTES + 1);
  localparam int REFRESH_CLKS = QUANTUM_CLKS * REFRESH_QUANTA;

  logic [LVL_W-1:0] act_lvl, deact_lvl;
  logic             fc_ok;
  logic             run;

  rxfc_thresh_decode #(.FIFO_BYTES(FIFO_BYTES), .LVL_W(LVL_W)) u_dec (
    .clk(clk), .rst(rst), .ctrl_word(dma_ctrl),
    .act_lvl(act_lvl), .deact_lvl(deact_lvl), .cfg_err(cfg_err), .fc_ok(fc_ok)
  );

  assign run = fc_ok && tx_fc_en;

  rxfc_pause_fsm #(.LVL_W(LVL_W), .REFRESH_CLKS(REFRESH_CLKS)) u_fsm (
    .clk(clk), .rst(rst), .run(run), .level(rx_fifo_level),
    .act_lvl(act_lvl), .deact_lvl(deact_lvl), .zq_dis(zero_quanta_dis),
    .ack(pause_ack), .req(pause_req), .ptime(pause_time), .xoff(xoff_active)
  );

  rxfc_rx_detect u_rx (
    .clk(clk), .rst(rst), .rx_en(rx_fc_en), .uni_en(uni_pause_en),
    .station(station_addr), .valid(rx_frame_valid), .da(rx_dest_addr),
    .etype(rx_ethertype), .opcode(rx_opcode), .quanta(rx_quanta),
    .hit(rx_pause_hit), .hit_quanta(rx_pause_quanta)
  );

  assert_err_mute_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && $past(cfg_err)) |-> !pause_req);
endmodule

// File: tb/rx_pause_flow_ctrl_tb.sv
module rx_pause_flow_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FIFO_MAIN  = 16384;
  localparam int QCLK       = 8;
  localparam int RQ         = 4;
  localparam int RCLK       = QCLK * RQ;
  localparam logic [47:0] MCAST = 48'h0180C2000001;
  localparam logic [47:0] STA   = 48'h02AABBCCDDEE;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst, tx_en, rx_en, uni_en, zq, ack, rxv;
  logic [31:0] ctrl;
  logic [14:0] lvl;
  logic [12:0] lvl_s;
  logic [11:0] lvl_t;
  logic [47:0] da;
  logic [15:0] et, op, qn;
  logic        req, xoff, err, hit;
  logic [15:0] ptime, hq;
  logic        req_s, xoff_s, err_s, hit_s;
  logic [15:0] ptime_s, hq_s;
  logic        req_t, xoff_t, err_t, hit_t;
  logic [15:0] ptime_t, hq_t;

  rx_pause_flow_ctrl #(.FIFO_BYTES(FIFO_MAIN), .QUANTUM_CLKS(QCLK), .REFRESH_QUANTA(RQ)) u_dut (
    .clk(clk), .rst(rst), .dma_ctrl(ctrl), .tx_fc_en(tx_en), .rx_fc_en(rx_en),
    .uni_pause_en(uni_en), .zero_quanta_dis(zq), .rx_fifo_level(lvl),
    .pause_req(req), .pause_time(ptime), .pause_ack(ack), .xoff_active(xoff), .cfg_err(err),
    .rx_frame_valid(rxv), .rx_dest_addr(da), .rx_ethertype(et), .rx_opcode(op),
    .rx_quanta(qn), .station_addr(STA), .rx_pause_hit(hit), .rx_pause_quanta(hq));

  rx_pause_flow_ctrl #(.FIFO_BYTES(4096), .QUANTUM_CLKS(QCLK), .REFRESH_QUANTA(RQ)) u_small (
    .clk(clk), .rst(rst), .dma_ctrl(ctrl), .tx_fc_en(tx_en), .rx_fc_en(rx_en),
    .uni_pause_en(uni_en), .zero_quanta_dis(zq), .rx_fifo_level(lvl_s),
    .pause_req(req_s), .pause_time(ptime_s), .pause_ack(ack), .xoff_active(xoff_s), .cfg_err(err_s),
    .rx_frame_valid(rxv), .rx_dest_addr(da), .rx_ethertype(et), .rx_opcode(op),
    .rx_quanta(qn), .station_addr(STA), .rx_pause_hit(hit_s), .rx_pause_quanta(hq_s));

  rx_pause_flow_ctrl #(.FIFO_BYTES(2048), .QUANTUM_CLKS(QCLK), .REFRESH_QUANTA(RQ)) u_tiny (
    .clk(clk), .rst(rst), .dma_ctrl(ctrl), .tx_fc_en(tx_en), .rx_fc_en(rx_en),
    .uni_pause_en(uni_en), .zero_quanta_dis(zq), .rx_fifo_level(lvl_t),
    .pause_req(req_t), .pause_time(ptime_t), .pause_ack(ack), .xoff_active(xoff_t), .cfg_err(err_t),
    .rx_frame_valid(rxv), .rx_dest_addr(da), .rx_ethertype(et), .rx_opcode(op),
    .rx_quanta(qn), .station_addr(STA), .rx_pause_hit(hit_t), .rx_pause_quanta(hq_t));

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  function automatic logic [31:0] mk_word(input logic [2:0] a, input logic [2:0] d);
    logic [31:0] w;
    w = 32'h0;
    w[23] = a[2]; w[10:9] = a[1:0];
    w[22] = d[2]; w[12:11] = d[1:0];
    return w;
  endfunction

  function automatic int lvl_of(input int fifo, input int code);
    return fifo - (code + 1) * 1024;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic ack_pulse();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic rx_frame(input logic [47:0] a, input logic [15:0] o, input logic [15:0] q);
    da = a; et = 16'h8808; op = o; qn = q; rxv = 1'b1;
    tick();
    rxv = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  // reference model state for the random phase
  logic    m_st, m_req;
  logic [15:0] m_time;
  int      m_cnt;

  initial begin
    rst = 1'b1; ctrl = mk_word(3'd0, 3'd1); tx_en = 1'b1; rx_en = 1'b1; uni_en = 1'b0;
    zq = 1'b0; ack = 1'b0; lvl = '0; lvl_s = '0; lvl_t = '0;
    rxv = 1'b0; da = '0; et = '0; op = '0; qn = '0;
    void'($urandom(32'd1234));
    repeat (3) tick();
    chk("R1 req", req, 0); chk("R1 xoff", xoff, 0); chk("R1 err", err, 0); chk("R1 hit", hit, 0);
    rst = 1'b0; tick();
    chk("R1 req after", req, 0);
    tick();
    chk("R2 legal default", err, 0);

    // activation edge
    lvl = 15'(lvl_of(FIFO_MAIN, 0) - 1); tick();
    chk("R3 below act", req, 0);
    lvl = 15'(lvl_of(FIFO_MAIN, 0)); tick();
    chk("R3 req", req, 1); chk("R3 time", ptime, 16'hFFFF); chk("R3 xoff", xoff, 1);
    repeat (3) tick();
    chk("R6 held", req, 1); chk("R6 time held", ptime, 16'hFFFF);
    ack_pulse();
    chk("R6 ack clears", req, 0);

    // hysteresis and release
    lvl = 15'(lvl_of(FIFO_MAIN, 1) + 1); repeat (2) tick();
    chk("R4 stays xoff", xoff, 1); chk("R4 no req", req, 0);
    lvl = 15'(lvl_of(FIFO_MAIN, 1)); tick();
    chk("R5 xon", xoff, 0); chk("R5 req", req, 1); chk("R5 zero time", ptime, 0);
    ack_pulse();
    chk("R6 xon acked", req, 0);

    // zero-quanta disable
    zq = 1'b1; lvl = 15'd15360; tick();
    chk("R3 again", req, 1);
    ack_pulse();
    lvl = 15'd14000; tick();
    chk("R5 zq xon", xoff, 0); chk("R5 zq no req", req, 0);
    zq = 1'b0;

    // refresh timing
    lvl = 15'd16000; tick();
    chk("R7 entry", req, 1);
    ack_pulse();
    chk("R7 acked", req, 0);
    repeat (RCLK - 2) tick();
    chk("R7 not yet", req, 0);
    tick();
    chk("R7 refresh", req, 1); chk("R7 refresh time", ptime, 16'hFFFF);
    ack_pulse();
    lvl = '0; tick();
    chk("R5 xon after refresh", ptime, 0);
    ack_pulse();

    // field positions with high bits
    ctrl = mk_word(3'd4, 3'd5); repeat (2) tick();
    chk("R2 err", err, 0);
    lvl = 15'(lvl_of(FIFO_MAIN, 4) - 1); tick();
    chk("R2 below act4", req, 0);
    lvl = 15'(lvl_of(FIFO_MAIN, 4)); tick();
    chk("R2 act4", xoff, 1);
    ack_pulse();
    lvl = 15'(lvl_of(FIFO_MAIN, 5) + 1); tick();
    chk("R2 above deact5", xoff, 1);
    lvl = 15'(lvl_of(FIFO_MAIN, 5)); tick();
    chk("R2 deact5", xoff, 0);
    ack_pulse();

    // illegal codes
    lvl = '0; ctrl = mk_word(3'd7, 3'd1); repeat (2) tick();
    chk("R8 reserved", err, 1);
    lvl = 15'd16384; repeat (2) tick();
    chk("R8 muted req", req, 0); chk("R8 muted xoff", xoff, 0);
    ctrl = mk_word(3'd2, 3'd2); repeat (2) tick();
    chk("R8 order", err, 1);
    lvl = '0; ctrl = mk_word(3'd3, 3'd4); repeat (2) tick();
    chk("R8 big ok", err, 0); chk("R8 small err", err_s, 1);
    lvl_s = 13'd4096; tick();
    chk("R8 small muted", req_s, 0);
    lvl_s = '0; ctrl = mk_word(3'd1, 3'd2); repeat (2) tick();
    chk("R8 small legal", err_s, 0);
    lvl_s = 13'd2047; tick();
    chk("R2 small below", req_s, 0);
    lvl_s = 13'd2048; tick();
    chk("R2 small act", req_s, 1);
    lvl_t = 12'd2048; repeat (2) tick();
    chk("R9 tiny req", req_t, 0); chk("R9 tiny err", err_t, 0);
    ctrl = mk_word(3'd7, 3'd7); repeat (2) tick();
    chk("R9 tiny err bad codes", err_t, 0);

    // transmit enable
    ctrl = mk_word(3'd0, 3'd1); lvl_s = '0; lvl_t = '0;
    ack = 1'b1; repeat (3) tick(); ack = 1'b0;
    tx_en = 1'b0; tick();
    lvl = 15'd16384; repeat (2) tick();
    chk("R10 no req", req, 0); chk("R10 no xoff", xoff, 0);
    tx_en = 1'b1; tick();
    chk("R10 re-enabled", req, 1);
    ack_pulse();
    lvl = '0; tick(); ack_pulse();

    // receive detection
    rx_frame(MCAST, 16'h0001, 16'h1234);
    chk("R11 mcast hit", hit, 1); chk("R11 quanta", hq, 16'h1234);
    tick();
    chk("R11 pulse", hit, 0);
    rx_frame(STA, 16'h0001, 16'h0042);
    chk("R11 uni off", hit, 0);
    uni_en = 1'b1;
    rx_frame(STA, 16'h0001, 16'h0042);
    chk("R11 uni on", hit, 1); chk("R11 uni quanta", hq, 16'h0042);
    rx_frame(48'h02AABBCCDD00, 16'h0001, 16'h0007);
    chk("R11 other uni", hit, 0);
    rx_frame(MCAST, 16'h0002, 16'h0007);
    chk("R11 bad opcode", hit, 0);
    rx_en = 1'b0;
    rx_frame(MCAST, 16'h0001, 16'h0009);
    chk("R11 rx disabled", hit, 0); chk("R11 quanta kept", hq, 16'h0042);
    rx_en = 1'b1;

    // random phase against the bench model
    rst = 1'b1; ctrl = mk_word(3'd0, 3'd1); lvl = '0; ack = 1'b0; zq = 1'b0; tx_en = 1'b1;
    repeat (2) tick();
    rst = 1'b0; repeat (2) tick();
    m_st = 1'b0; m_req = 1'b0; m_time = 16'h0; m_cnt = 0;
    for (int i = 0; i < 600; i++) begin
      int a_lvl, a_deact;
      logic nack, nzq;
      logic [14:0] nl;
      chk("R4 rnd xoff", xoff, m_st);
      chk("R6 rnd req", req, m_req);
      if (m_req) chk("R3 rnd time", ptime, m_time);
      nl   = 15'(13800 + $urandom_range(0, 2584));
      nack = ($urandom_range(0, 2) == 0);
      nzq  = ($urandom_range(0, 3) == 0);
      lvl = nl; ack = nack; zq = nzq;
      a_lvl = lvl_of(FIFO_MAIN, 0); a_deact = lvl_of(FIFO_MAIN, 1);
      if (!m_st) begin
        if (int'(nl) >= a_lvl) begin m_st = 1'b1; m_req = 1'b1; m_time = 16'hFFFF; m_cnt = 0; end
        else if (nack) m_req = 1'b0;
      end else begin
        if (int'(nl) <= a_deact) begin m_st = 1'b0; m_cnt = 0; m_req = !nzq; m_time = 16'h0; end
        else if (m_cnt == RCLK - 1) begin m_req = 1'b1; m_time = 16'hFFFF; m_cnt = 0; end
        else begin m_cnt++; if (nack) m_req = 1'b0; end
      end
      tick();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule